// File: doc/BRIEF.md
# Ring-Fed Memory Copy Engine

This block is a single-channel copy engine that takes its work from a submission ring in memory and reports back through a completion ring. Software places 32-byte entries in the submission ring and then moves the tail index forward. The engine compares that tail with its own head index. For each pending entry it reads the eight 32-bit words, decodes the operation, and copies the requested bytes from the source buffer to the destination buffer. It then writes a 16-byte completion entry and, if the entry asks for it, raises an interrupt.

Entries run strictly in order and one at a time. A single memory port carries every access: descriptor fetch, data reads, data writes and completion writes. The request side uses valid/ready. Once `mem_req_valid` is high it stays high, and address, write flag and write data stay unchanged, until `mem_req_ready` is sampled high. At most one read is outstanding. Its data returns on `mem_rsp_valid` for exactly one cycle and is always accepted. There is no response ready. Writes need no response.

Ring bases, ring depth minus one, enable, pause, the software tail and the software completion head are plain configuration inputs. They must be stable while the engine is active. Addresses are `AW` bits wide. Only the low 32-bit word of each 64-bit address in an entry is used.

Top module: `ring_dma_engine`

## Requirements
- R1: When enable is high, pause is low and `sq_tail` differs from the internal head index, the engine reads the eight words of the entry at `cfg_sq_base + head*32`, in order from offset 0 to offset 28. Control word bits 3:0 are the opcode and bit 8 is the interrupt request. Word 3 is the byte length. Word 4 is the source address and word 6 is the destination address. Words 1, 5 and 7 and the attribute fields are ignored.
- R2: Opcode 0x4 and opcode 0x1 both copy ceil(length/4) 32-bit words, moving upward from source to destination. Each word is read, then written. A length of 0 moves no data.
- R3: Any other opcode performs no data write, and its completion carries status 1.
- R4: Each completion performs two writes, and the second write marks the entry valid. The first writes `cfg_cq_base + cqtail*16 + 8`; its low 16 bits hold the submission head index after this entry was consumed, and its upper 16 bits are zero. The second writes offset 12; its bits 31:16 hold {status[14:0], valid=1}. Success is therefore 0x0001_0000 and a bad opcode is 0x0003_0000.
- R5: The submission head and the completion tail each advance by one per entry. Both wrap to 0 after reaching `cfg_depth_m1`.
- R6: The enable and pause inputs are only checked between entries. With pause high or enable low, no new fetch starts and no memory request is made while idle. An entry already started runs to completion.
- R7: The completion entry is not written while the ring is full, meaning the next completion tail equals `cq_head`. It is written once software moves `cq_head` forward.
- R8: When the entry's interrupt bit is set, `irq` pulses high for exactly one cycle, in the cycle after the valid-bearing completion write is accepted. If the bit is clear, `irq` stays low.
- R9: A request held without ready keeps valid, address, write flag and write data unchanged until it is accepted.
- R10: After reset, both indices are 0, `irq` is low and no request is made until work is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Channel enable, checked between entries |
| cfg_pause | input | 1 | Stop fetching after the current entry |
| cfg_sq_base | input | AW | Byte address of submission ring slot 0 |
| cfg_cq_base | input | AW | Byte address of completion ring slot 0 |
| cfg_depth_m1 | input | IW | Ring depth minus one (both rings) |
| sq_tail | input | IW | Software submission tail doorbell |
| cq_head | input | IW | Software completion head |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Byte address, word aligned |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid (one cycle) |
| mem_rsp_data | input | 32 | Read data |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The bench stalls the memory port one cycle in four. An engine that dropped or changed a stalled request would lose or corrupt words.

It runs the ring through several wraps. An engine with a wrong wrap point would write completions to the wrong slot, or report a wrong head index.

It sends a length of 5 bytes, a length of 0 and an unknown opcode. Wrong rounding, a zero-length copy or movement on a bad opcode shows up as an overwritten sentinel word in the destination buffer.

It holds work pending under pause, under enable low, and against a full completion ring. An engine that ignored these would fetch or publish a completion too early.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_DRD, S_DWT, S_DEC, S_CRD, S_CWT, S_CWR, S_QCHK, S_QW2, S_QW3
  } eng_state_e;

  localparam logic [3:0]  OP_COPY  = 4'h4;
  localparam logic [3:0]  OP_SMALL = 4'h1;
  localparam logic [14:0] STS_OK   = 15'd0;
  localparam logic [14:0] STS_BAD  = 15'd1;
  localparam int          ENTRY_WORDS = 8;
endpackage

// File: rtl/ring_ptr.sv
module ring_ptr #(
  parameter int IW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [IW-1:0] depth_m1,
  output logic [IW-1:0] idx,
  output logic [IW-1:0] nxt
);
  assign nxt = (idx == depth_m1) ? '0 : idx + IW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)   idx <= '0;
    else if (adv) idx <= nxt;
  end

  // R5
  idx_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= depth_m1);
endmodule

// File: rtl/entry_decode.sv
module entry_decode (
  input  logic [3:0]  opcode,
  input  logic [31:0] byte_len,
  output logic        op_ok,
  output logic [30:0] n_words
);
  import ring_dma_pkg::*;
  logic [32:0] rounded;

  assign op_ok   = (opcode == OP_COPY) || (opcode == OP_SMALL);
  assign rounded = {1'b0, byte_len} + 33'd3;
  assign n_words = rounded[32:2];
endmodule

// File: rtl/ring_dma_engine.sv
module ring_dma_engine #(
  parameter int AW = 32,
  parameter int IW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_enable,
  input  logic          cfg_pause,
  input  logic [AW-1:0] cfg_sq_base,
  input  logic [AW-1:0] cfg_cq_base,
  input  logic [IW-1:0] cfg_depth_m1,
  input  logic [IW-1:0] sq_tail,
  input  logic [IW-1:0] cq_head,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [31:0]   mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  output logic          irq
);
  import ring_dma_pkg::*;

  localparam int WIX_W = $clog2(ENTRY_WORDS);

  eng_state_e        st;
  logic [WIX_W-1:0]  widx;
  logic [3:0]        op_q;
  logic              ien_q;
  logic [31:0]       len_q;
  logic [AW-1:0]     cur_src, cur_dst;
  logic [30:0]       cnt;
  logic [31:0]       dbuf;
  logic [14:0]       status_q;
  logic [IW-1:0]     sq_idx, sq_nxt, cq_idx, cq_nxt;
  logic              op_ok;
  logic [30:0]       n_words;
  logic              hs, done_adv, cq_full;

  assign hs       = mem_req_valid && mem_req_ready;
  assign done_adv = (st == S_QW3) && hs;
  assign cq_full  = (cq_nxt == cq_head);

  ring_ptr #(.IW(IW)) u_sq_ptr (
    .clk(clk), .rst_n(rst_n), .adv(done_adv), .depth_m1(cfg_depth_m1),
    .idx(sq_idx), .nxt(sq_nxt));

  ring_ptr #(.IW(IW)) u_cq_ptr (
    .clk(clk), .rst_n(rst_n), .adv(done_adv), .depth_m1(cfg_depth_m1),
    .idx(cq_idx), .nxt(cq_nxt));

  entry_decode u_dec (
    .opcode(op_q), .byte_len(len_q), .op_ok(op_ok), .n_words(n_words));

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = '0;
    mem_req_wdata = '0;
    unique case (st)
      S_DRD: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = cfg_sq_base + AW'({sq_idx, 5'b0}) + AW'({widx, 2'b0});
      end
      S_CRD: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = cur_src;
      end
      S_CWR: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_addr  = cur_dst;
        mem_req_wdata = dbuf;
      end
      S_QW2: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_addr  = cfg_cq_base + AW'({cq_idx, 4'b0}) + AW'(8);
        mem_req_wdata = {16'h0, 16'(sq_nxt)};
      end
      S_QW3: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_addr  = cfg_cq_base + AW'({cq_idx, 4'b0}) + AW'(12);
        mem_req_wdata = {status_q, 1'b1, 16'h0};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      widx     <= '0;
      op_q     <= '0;
      ien_q    <= 1'b0;
      len_q    <= '0;
      cur_src  <= '0;
      cur_dst  <= '0;
      cnt      <= '0;
      dbuf     <= '0;
      status_q <= STS_OK;
      irq      <= 1'b0;
    end else begin
      irq <= done_adv && ien_q;
      unique case (st)
        S_IDLE:
          if (cfg_enable && !cfg_pause && (sq_idx != sq_tail)) begin
            widx <= '0;
            st   <= S_DRD;
          end
        S_DRD: if (hs) st <= S_DWT;
        S_DWT:
          if (mem_rsp_valid) begin
            case (widx)
              WIX_W'(0): begin op_q <= mem_rsp_data[3:0]; ien_q <= mem_rsp_data[8]; end
              WIX_W'(3): len_q   <= mem_rsp_data;
              WIX_W'(4): cur_src <= mem_rsp_data[AW-1:0];
              WIX_W'(6): cur_dst <= mem_rsp_data[AW-1:0];
              default: ;
            endcase
            if (widx == WIX_W'(ENTRY_WORDS - 1)) st <= S_DEC;
            else begin
              widx <= widx + WIX_W'(1);
              st   <= S_DRD;
            end
          end
        S_DEC: begin
          cnt <= n_words;
          if (!op_ok) begin
            status_q <= STS_BAD;
            st       <= S_QCHK;
          end else begin
            status_q <= STS_OK;
            st       <= (n_words == '0) ? S_QCHK : S_CRD;
          end
        end
        S_CRD: if (hs) st <= S_CWT;
        S_CWT:
          if (mem_rsp_valid) begin
            dbuf <= mem_rsp_data;
            st   <= S_CWR;
          end
        S_CWR:
          if (hs) begin
            cur_src <= cur_src + AW'(4);
            cur_dst <= cur_dst + AW'(4);
            cnt     <= cnt - 31'd1;
            st      <= (cnt == 31'd1) ? S_QCHK : S_CRD;
          end
        S_QCHK: if (!cq_full) st <= S_QW2;
        S_QW2:  if (hs) st <= S_QW3;
        S_QW3:  if (hs) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata)));

  // R8
  irq_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(mem_req_valid && mem_req_ready && mem_req_we));

  // R3
  badop_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEC && !op_ok) |=> !mem_req_valid);

  // R6
  pause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cfg_pause) |=> !mem_req_valid);

  // R7
  cq_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_QCHK && cq_full && $stable(cq_head)) |=> !mem_req_valid);
endmodule

// File: tb/ring_dma_engine_tb.sv
module ring_dma_engine_tb_top;
  localparam int AW = 32;
  localparam int IW = 10;
  localparam logic [31:0] SQB = 32'h0000_0100;
  localparam logic [31:0] CQB = 32'h0000_0400;

  typedef struct packed {
    logic [3:0]  op;
    logic        ien;
    logic [31:0] len;
    logic [31:0] w3;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{4'h4, 1'b1, 32'd16, 32'h0001_0000},
    '{4'h1, 1'b0, 32'd8,  32'h0001_0000},
    '{4'h4, 1'b1, 32'd0,  32'h0001_0000},
    '{4'h7, 1'b1, 32'd8,  32'h0003_0000},
    '{4'h4, 1'b0, 32'd5,  32'h0001_0000},
    '{4'h1, 1'b1, 32'd12, 32'h0001_0000}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          cfg_enable, cfg_pause;
  logic [IW-1:0] cfg_depth_m1, sq_tail, cq_head;
  logic          req_valid, req_ready, req_we;
  logic [AW-1:0] req_addr;
  logic [31:0]   req_wdata, rsp_data;
  logic          rsp_valid, irq;

  ring_dma_engine #(.AW(AW), .IW(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_pause(cfg_pause),
    .cfg_sq_base(SQB), .cfg_cq_base(CQB), .cfg_depth_m1(cfg_depth_m1),
    .sq_tail(sq_tail), .cq_head(cq_head),
    .mem_req_valid(req_valid), .mem_req_ready(req_ready), .mem_req_we(req_we),
    .mem_req_addr(req_addr), .mem_req_wdata(req_wdata),
    .mem_rsp_valid(rsp_valid), .mem_rsp_data(rsp_data), .irq(irq));

  logic [31:0] mem [0:4095];
  logic [7:0]  rdy_cnt = 8'd0;
  assign req_ready = (rdy_cnt[1:0] != 2'b11);

  always @(posedge clk) begin
    rdy_cnt   <= rdy_cnt + 8'd1;
    rsp_valid <= 1'b0;
    if (req_valid && req_ready) begin
      if (req_we) mem[req_addr[13:2]] = req_wdata;
      else begin
        rsp_data  <= mem[req_addr[13:2]];
        rsp_valid <= 1'b1;
      end
    end
  end

  int irq_cnt = 0;
  always @(posedge clk) if (irq) irq_cnt <= irq_cnt + 1;

  // R9 monitor: a stalled request must be repeated unchanged
  int hold_err = 0;
  logic          p_stall = 1'b0;
  logic [AW-1:0] p_addr;
  logic [31:0]   p_wdata;
  logic          p_we;
  always @(negedge clk) begin
    if (p_stall && !(req_valid && req_addr == p_addr && req_we == p_we && req_wdata == p_wdata))
      hold_err++;
    p_stall = rst_n && req_valid && !req_ready;
    p_addr  = req_addr;
    p_we    = req_we;
    p_wdata = req_wdata;
  end

  int n_chk = 0, n_fail = 0, sub_n = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic int cq_w(input int n, input int off);
    return (int'(CQB) + (n % 4) * 16 + off) / 4;
  endfunction

  function automatic int src_of(input int n); return 32'h1000 + (n % 8) * 32'h40; endfunction
  function automatic int dst_of(input int n); return 32'h2000 + (n % 8) * 32'h40; endfunction

  task automatic submit(input logic [3:0] op, input logic ien, input logic [31:0] len);
    int b;
    b = (int'(SQB) + (sub_n % 4) * 32) / 4;
    for (int k = 0; k < 4; k++) begin
      mem[src_of(sub_n) / 4 + k] = 32'hA000_0000 + sub_n * 256 + k;
      mem[dst_of(sub_n) / 4 + k] = 32'h5EED_0000 + k;
    end
    mem[b + 0] = {17'h0, 3'b010, 3'b000, ien, 4'h0, op};
    mem[b + 1] = 32'hFFFF_FFFF;
    mem[b + 2] = {5'h0, 3'b011, 24'h0};
    mem[b + 3] = len;
    mem[b + 4] = src_of(sub_n);
    mem[b + 5] = 32'h0;
    mem[b + 6] = dst_of(sub_n);
    mem[b + 7] = 32'h0;
    mem[cq_w(sub_n, 8)]  = 32'h0;
    mem[cq_w(sub_n, 12)] = 32'h0;
    @(negedge clk);
    sq_tail = IW'((sub_n + 1) % 4);
    sub_n++;
  endtask

  task automatic wait_done(input int n, output bit ok);
    ok = 0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (mem[cq_w(n, 12)] != 32'h0) begin ok = 1; break; end
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit ok;
    int n, i0, vcnt;
    logic [31:0] e;
    rst_n = 1'b0; cfg_enable = 1'b1; cfg_pause = 1'b0;
    cfg_depth_m1 = IW'(3); sq_tail = '0; cq_head = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    vcnt = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (req_valid || irq) vcnt++;
    end
    // R10
    chk(vcnt == 0, "R10 reset quiet", vcnt, 0);

    // Vector table: R1 R2 R3 R4 R5 R8
    for (int v = 0; v < 6; v++) begin
      n = sub_n; i0 = irq_cnt;
      submit(VEC[v].op, VEC[v].ien, VEC[v].len);
      wait_done(n, ok);
      chk(ok, "R1 completion seen", 32'(ok), 1);
      chk(mem[cq_w(n, 12)] == VEC[v].w3, "R4 R3 status word", mem[cq_w(n, 12)], VEC[v].w3);
      chk(mem[cq_w(n, 8)] == 32'((n + 1) % 4), "R5 head field", mem[cq_w(n, 8)], 32'((n + 1) % 4));
      for (int k = 0; k < 4; k++) begin
        e = ((VEC[v].op == 4'h4 || VEC[v].op == 4'h1) && k < (VEC[v].len + 3) / 4)
            ? 32'hA000_0000 + n * 256 + k : 32'h5EED_0000 + k;
        chk(mem[dst_of(n) / 4 + k] == e, "R2 R3 dst word", mem[dst_of(n) / 4 + k], e);
      end
      chk(irq_cnt - i0 == int'(VEC[v].ien), "R8 irq count", irq_cnt - i0, 32'(VEC[v].ien));
      cq_head = IW'((n + 1) % 4);
    end

    // R6: pause, then enable low, hold a pending entry
    for (int j = 0; j < 2; j++) begin
      if (j == 0) cfg_pause = 1'b1; else cfg_enable = 1'b0;
      n = sub_n;
      submit(4'h4, 1'b0, 32'd8);
      vcnt = 0;
      for (int c = 0; c < 60; c++) begin
        @(negedge clk);
        if (req_valid) vcnt++;
      end
      chk(vcnt == 0, "R6 no fetch while held", vcnt, 0);
      chk(mem[dst_of(n) / 4] == 32'h5EED_0000, "R6 dst untouched", mem[dst_of(n) / 4], 32'h5EED_0000);
      cfg_pause = 1'b0; cfg_enable = 1'b1;
      wait_done(n, ok);
      chk(ok && mem[dst_of(n) / 4] == 32'hA000_0000 + n * 256, "R6 resumes", mem[dst_of(n) / 4], 32'hA000_0000 + n * 256);
      cq_head = IW'((n + 1) % 4);
    end

    // R7: completion ring full
    for (int j = 0; j < 3; j++) begin
      n = sub_n;
      submit(4'h4, 1'b0, 32'd4);
      wait_done(n, ok);
      chk(ok, "R7 fill entry done", 32'(ok), 1);
    end
    n = sub_n;
    submit(4'h4, 1'b1, 32'd4);
    repeat (100) @(negedge clk);
    chk(mem[cq_w(n, 12)] == 32'h0, "R7 held while full", mem[cq_w(n, 12)], 0);
    cq_head = IW'(n % 4);
    wait_done(n, ok);
    chk(ok && mem[cq_w(n, 12)] == 32'h0001_0000, "R7 released", mem[cq_w(n, 12)], 32'h0001_0000);
    cq_head = IW'((n + 1) % 4);

    // R9
    chk(hold_err == 0, "R9 stalled request stable", hold_err, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule